// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns one requested programmed-I/O transfer cycle into the three clock counts a drive timing sequencer needs: address setup, strobe active and strobe recovery. The caller supplies the setup time, the active time and the total cycle time in nanoseconds, the bus clock period in nanoseconds, a two-bit controller revision and, for a channel whose two drives share one timing set, the already computed counts of the other drive. A one-cycle `start` pulse latches all of these inputs. The block then divides each time by the clock period with a single subtract-based divider, applies the minimum, maximum and carry rules, and presents a two-bit setup code and a packed active/recovery byte together with a one-cycle `done` pulse.

All arithmetic is rounded up, so a programmed interval is never shorter than the one requested. The work is spread over several cycles: the latency depends on the size of the quotients, and the caller waits for `done`.

Top module: `pio_count_calc`

## Requirements
- R1: The setup, active, recovery-time and cycle counts are each the ceiling of the time divided by the clock period; a clock period of 0 is treated as 1 ns.
- R2: Recovery time is the cycle time less the sum of setup and active times, saturating at 0. The recovery count is the larger of its own ceiling and (cycle count minus setup count minus the raised active count, saturating at 0), and is then raised to at least 2.
- R3: An active count below 2 is raised to 2 before it is used anywhere.
- R4: A recovery count above 17 moves its excess onto the active count and becomes 17; the active count is then limited to 16.
- R5: When the revision input is 2 or 3, the recovery count is reduced by one; afterwards it is limited to 16 for every revision.
- R6: `setup_code` is 2'b00 for a setup count of 4, 2'b10 for 3, 2'b01 for 1 or 2, and 2'b11 for any other value; `drw_byte[7:4]` holds the active count and `drw_byte[3:0]` the recovery count, each modulo 16 so that 16 is written as 0.
- R7: When `mate_en` is high at start, each final count (setup, active, recovery after R5) is replaced by the larger of itself and the matching mate count; mate active and recovery counts are given in the range 1 to 16.
- R8: `done` is high for exactly one cycle per accepted start, on the cycle after edge N counted from the start edge (edge 0), where N is 5 plus the sum of the four quotients of R1; `setup_code` and `drw_byte` change only together with `done` and hold until the next one.
- R9: Inputs are sampled only on the edge that accepts `start`; `start` while a computation is in progress, and changes to the data inputs during it, have no effect on the result or its timing.
- R10: After reset `done` is 0, `setup_code` is 2'b00 and `drw_byte` is 8'h00 (the slowest timing).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation; ignored while busy |
| setup_ns | input | TW | Address setup time in ns |
| active_ns | input | TW | Strobe active time in ns |
| cycle_ns | input | TW | Total transfer cycle time in ns |
| clk_ns | input | TW | Bus clock period in ns (0 treated as 1) |
| rev | input | 2 | Controller revision; 2 or 3 selects the reduced recovery encoding |
| mate_en | input | 1 | Merge with the other drive of a shared channel |
| mate_setup | input | CW | Other drive's setup count |
| mate_active | input | 5 | Other drive's active count (1 to 16) |
| mate_recov | input | 5 | Other drive's recovery count (1 to 16) |
| done | output | 1 | One-cycle result strobe |
| setup_code | output | 2 | Encoded setup count |
| drw_byte | output | 8 | Packed active (high nibble) and recovery (low nibble) counts |

## Verification
The result is due a data-dependent number of cycles after the start edge: one cycle per unit of each of the four quotients, one more per division to store it, and one finishing cycle, so the bench computes that edge count from its own quotients and compares it with the edge on which `done` is first seen. All outputs are sampled on the falling edge, the cycle after `done` is checked for its fall and for unchanged outputs, and stimulus injected part way through a computation is judged by the unchanged result and unchanged latency of that computation.

// File: rtl/pio_count_calc.sv
module pio_count_calc #(
  parameter int TW = 10,
  parameter int CW = TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] setup_ns,
  input  logic [TW-1:0] active_ns,
  input  logic [TW-1:0] cycle_ns,
  input  logic [TW-1:0] clk_ns,
  input  logic [1:0]    rev,
  input  logic          mate_en,
  input  logic [CW-1:0] mate_setup,
  input  logic [4:0]    mate_active,
  input  logic [4:0]    mate_recov,
  output logic          done,
  output logic [1:0]    setup_code,
  output logic [7:0]    drw_byte
);
  localparam int XW = CW + 2;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_t;
  st_t st;

  logic [1:0]    idx;
  logic [TW-1:0] rem, per;
  logic [CW-1:0] quo;
  logic [TW-1:0] ts, ta, tc;
  logic [1:0]    rv;
  logic          men;
  logic [CW-1:0] ms;
  logic [4:0]    ma, mr;
  logic [CW-1:0] cs, ca, cr, cc;

  logic [TW:0]   t_sa;
  logic [TW-1:0] t_rec, next_div;

  assign t_sa  = {1'b0, ts} + {1'b0, ta};
  assign t_rec = ({1'b0, tc} > t_sa) ? TW'({1'b0, tc} - t_sa) : '0;

  always_comb begin
    case (idx)
      2'd0:    next_div = ta;
      2'd1:    next_div = t_rec;
      default: next_div = tc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
      rem <= '0;
      quo <= '0;
      per <= '0;
      ts  <= '0;
      ta  <= '0;
      tc  <= '0;
      rv  <= '0;
      men <= 1'b0;
      ms  <= '0;
      ma  <= '0;
      mr  <= '0;
      cs  <= '0;
      ca  <= '0;
      cr  <= '0;
      cc  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ts  <= setup_ns;
          ta  <= active_ns;
          tc  <= cycle_ns;
          per <= (clk_ns == '0) ? TW'(1) : clk_ns;
          rv  <= rev;
          men <= mate_en;
          ms  <= mate_setup;
          ma  <= mate_active;
          mr  <= mate_recov;
          rem <= setup_ns;
          quo <= '0;
          idx <= '0;
          st  <= S_DIV;
        end
        S_DIV: if (rem == '0) begin
          case (idx)
            2'd0:    cs <= quo;
            2'd1:    ca <= quo;
            2'd2:    cr <= quo;
            default: cc <= quo;
          endcase
          quo <= '0;
          if (idx == 2'd3) st <= S_FIN;
          else begin
            rem <= next_div;
            idx <= idx + 2'd1;
          end
        end else begin
          rem <= (rem > per) ? rem - per : '0;
          quo <= quo + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [XW-1:0] xs, xa, xr, xc;
  logic [XW-1:0] a_min, s_plus_a, r_alt, r_max, r_min, a_carry, r_cap17;
  logic [XW-1:0] a_fin, r_rev, r_fin, s_out, a_out, r_out;

  assign xs = XW'(cs);
  assign xa = XW'(ca);
  assign xr = XW'(cr);
  assign xc = XW'(cc);

  always_comb begin
    a_min    = (xa < XW'(2)) ? XW'(2) : xa;
    s_plus_a = xs + a_min;
    r_alt    = (xc > s_plus_a) ? xc - s_plus_a : '0;
    r_max    = (r_alt > xr) ? r_alt : xr;
    r_min    = (r_max < XW'(2)) ? XW'(2) : r_max;
    if (r_min > XW'(17)) begin
      a_carry = a_min + (r_min - XW'(17));
      r_cap17 = XW'(17);
    end else begin
      a_carry = a_min;
      r_cap17 = r_min;
    end
    a_fin = (a_carry > XW'(16)) ? XW'(16) : a_carry;
    r_rev = (rv > 2'd1) ? r_cap17 - XW'(1) : r_cap17;
    r_fin = (r_rev > XW'(16)) ? XW'(16) : r_rev;
    s_out = (men && XW'(ms) > xs) ? XW'(ms) : xs;
    a_out = (men && XW'(ma) > a_fin) ? XW'(ma) : a_fin;
    r_out = (men && XW'(mr) > r_fin) ? XW'(mr) : r_fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      setup_code <= 2'b00;
      drw_byte   <= 8'h00;
    end else begin
      done <= (st == S_FIN);
      if (st == S_FIN) begin
        case (s_out)
          XW'(4):          setup_code <= 2'b00;
          XW'(3):          setup_code <= 2'b10;
          XW'(1), XW'(2):  setup_code <= 2'b01;
          default:         setup_code <= 2'b11;
        endcase
        drw_byte <= {a_out[3:0], r_out[3:0]};
      end
    end
  end
endmodule

module pio_count_calc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [1:0] setup_code,
  input logic [7:0] drw_byte
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending <= 1'b0;
    else if (done) pending <= start;
    else if (start) pending <= 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pending); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({setup_code, drw_byte})); // R8

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$isunknown({setup_code, drw_byte})); // R6
endmodule

bind pio_count_calc pio_count_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .setup_code(setup_code), .drw_byte(drw_byte)
);

// File: tb/pio_count_calc_tb.sv
module pio_count_calc_tb;
  localparam int TW = 10;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [TW-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0, clk_ns = '0;
  logic [1:0]    rev = '0;
  logic          mate_en = 1'b0;
  logic [CW-1:0] mate_setup = '0;
  logic [4:0]    mate_active = '0, mate_recov = '0;
  logic          done;
  logic [1:0]    setup_code;
  logic [7:0]    drw_byte;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pio_count_calc #(.TW(TW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns), .clk_ns(clk_ns),
    .rev(rev), .mate_en(mate_en), .mate_setup(mate_setup),
    .mate_active(mate_active), .mate_recov(mate_recov),
    .done(done), .setup_code(setup_code), .drw_byte(drw_byte)
  );

  function automatic int cdiv(input int d, input int p);
    return (d + p - 1) / p;
  endfunction

  function automatic void model(input int ts, ta, tc, tk, rv, men, ms, ma, mr,
                                output logic [1:0] code, output logic [7:0] drw,
                                output int lat);
    int p, rt, cs, ca, cr, cc, a, r, r2, s;
    p  = (tk == 0) ? 1 : tk;
    rt = (tc > ts + ta) ? tc - ts - ta : 0;
    cs = cdiv(ts, p); ca = cdiv(ta, p); cr = cdiv(rt, p); cc = cdiv(tc, p);
    lat = cs + ca + cr + cc + 5;
    a  = (ca < 2) ? 2 : ca;
    r2 = (cc > cs + a) ? cc - cs - a : 0;
    r  = (r2 > cr) ? r2 : cr;
    if (r < 2) r = 2;
    if (r > 17) begin a = a + r - 17; r = 17; end
    if (a > 16) a = 16;
    if (rv > 1) r = r - 1;
    if (r > 16) r = 16;
    s = cs;
    if (men != 0) begin
      if (ms > s) s = ms;
      if (ma > a) a = ma;
      if (mr > r) r = mr;
    end
    case (s)
      4: code = 2'b00;
      3: code = 2'b10;
      1, 2: code = 2'b01;
      default: code = 2'b11;
    endcase
    drw = {4'(a % 16), 4'(r % 16)};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input int ts, ta, tc, tk, rv, men, ms, ma, mr,
                        input bit disturb);
    logic [1:0] ecode;
    logic [7:0] edrw;
    int lat, cnt;
    model(ts, ta, tc, tk, rv, men, ms, ma, mr, ecode, edrw, lat);
    @(negedge clk);
    setup_ns = TW'(ts); active_ns = TW'(ta); cycle_ns = TW'(tc); clk_ns = TW'(tk);
    rev = 2'(rv); mate_en = men[0]; mate_setup = CW'(ms);
    mate_active = 5'(ma); mate_recov = 5'(mr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (disturb && cnt == 1) begin
        setup_ns = TW'($urandom_range(0, 500)); active_ns = TW'($urandom_range(0, 500));
        cycle_ns = TW'($urandom_range(0, 900)); clk_ns = TW'($urandom_range(1, 9));
        rev = 2'($urandom_range(0, 3)); mate_en = ~mate_en;
        mate_setup = CW'($urandom_range(0, 9));
        mate_active = 5'($urandom_range(1, 16)); mate_recov = 5'($urandom_range(1, 16));
        start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(tag, "done latency (R8)", cnt, lat);
    check(tag, "setup_code", int'(setup_code), int'(ecode));
    check(tag, "drw_byte", int'(drw_byte), int'(edrw));
    @(negedge clk);
    check(tag, "done falls after one cycle (R8)", int'(done), 0);
    check(tag, "outputs hold (R8)", int'({setup_code, drw_byte}), int'({ecode, edrw}));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R10", "reset done", int'(done), 0);
    check("R10", "reset setup_code", int'(setup_code), 0);
    check("R10", "reset drw_byte", int'(drw_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 R6 basic", 70, 165, 600, 30, 1, 0, 0, 0, 0, 0);
    run_op("R5 rev2", 70, 165, 600, 30, 2, 0, 0, 0, 0, 0);
    run_op("R5 rev3 exact", 60, 90, 300, 30, 3, 0, 0, 0, 0, 0);
    run_op("R3 active min", 25, 10, 120, 30, 1, 0, 0, 0, 0, 0);
    run_op("R2 recovery floor", 30, 60, 90, 30, 0, 0, 0, 0, 0, 0);
    run_op("R2 cycle slack", 29, 59, 181, 30, 0, 0, 0, 0, 0, 0);
    run_op("R4 overflow carry", 30, 80, 900, 30, 1, 0, 0, 0, 0, 0);
    run_op("R4 active cap", 20, 80, 1000, 20, 2, 0, 0, 0, 0, 0);
    run_op("R4 recovery 17 rev1", 10, 40, 220, 10, 1, 0, 0, 0, 0, 0);
    run_op("R1 zero period", 3, 1, 12, 0, 0, 0, 0, 0, 0, 0);
    run_op("R6 setup zero", 0, 100, 300, 25, 0, 0, 0, 0, 0, 0);
    run_op("R6 setup large", 200, 100, 600, 30, 0, 0, 0, 0, 0, 0);
    run_op("R7 mate larger", 30, 90, 300, 30, 0, 1, 4, 12, 9, 0);
    run_op("R7 mate smaller", 100, 300, 900, 30, 2, 1, 1, 2, 1, 0);
    run_op("R7 mate off", 30, 90, 300, 30, 0, 0, 5, 16, 16, 0);
    run_op("R9 disturbed", 70, 165, 600, 30, 1, 0, 0, 0, 0, 1);
    run_op("R9 disturbed mate", 30, 90, 300, 30, 2, 1, 3, 7, 7, 1);

    for (int i = 0; i < 40; i++) begin
      run_op("R1 R2 R3 R4 R5 R6 R7 random",
             $urandom_range(0, 120), $urandom_range(0, 300), $urandom_range(0, 700),
             $urandom_range(5, 60), $urandom_range(0, 3), $urandom_range(0, 1),
             $urandom_range(0, 6), $urandom_range(1, 16), $urandom_range(1, 16),
             ($urandom_range(0, 3) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule